// File: doc/BRIEF.md
# Sine-Modulated PWM Generator with Minimum On-Time

This block turns a stream of sine-derived duty samples into a pulse-width-modulated gate signal for a power switch stage with high-side and low-side drivers. Each carrier period has a constant length of `total + 2*minimum` clocks. The period splits into a low phase followed by a high phase. The high phase lasts `duty + minimum` clocks and the low phase lasts `total + minimum - duty` clocks. As a result no high pulse is ever shorter than the programmed minimum, which keeps slow switches out of their linear region. Low phases may be as short as the minimum, and the sum of the two phases stays fixed.

A new duty sample can arrive at any time through a valid strobe. The most recent one is taken only where a period begins, together with the minimum and total settings, so a period never mixes values. A duty value above the total saturates. A second output can drive the complementary leg of a full bridge. The carrier runs only while the settings are consistent (minimum nonzero and total above minimum). Otherwise both outputs rest low.

Top module: `sinePwmTop`

## Requirements
- R1: While synchronous active-high reset is asserted, both outputs are low at every following clock. After release the carrier restarts with a low phase.
- R2: The high phase lasts exactly `min(duty, total) + minimum` clocks, where duty, minimum and total are the values captured at the start of that period.
- R3: The low phase lasts exactly `total + minimum - min(duty, total)` clocks, so each period lasts `total + 2*minimum` clocks.
- R4: A duty above total saturates to total, which gives a high phase of `total + minimum` and a low phase of `minimum`.
- R5: Every high pulse on `pwmOut` lasts at least the minimum that was in force during that pulse.
- R6: Duty, minimum and total are captured only at the clock where a low phase begins. A change during a period takes effect in the next period only.
- R7: With `diffEn` = 1, `pwmOutN` is the inverse of `pwmOut` while the carrier runs. The two outputs are never high together.
- R8: With `diffEn` = 0, `pwmOutN` stays low.
- R9: When minimum is 0 or total is not greater than minimum at a capture point, both outputs stay low. Settings are then re-checked every clock, and the carrier restarts with a low phase once they become valid.
- R10: `sampleDuty` is taken only in a clock where `sampleValid` is 1. Of several such samples, the last one before the capture point wins. A sample presented in the capture clock itself is used at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | Qualifies `sampleDuty` |
| sampleDuty | input | W | Duty sample in clocks |
| cfgMin | input | W | Minimum high width in clocks |
| cfgTotal | input | W | Duty full scale; period is total + 2*minimum |
| diffEn | input | 1 | Enables the complementary output |
| pwmOut | output | 1 | Modulated gate drive |
| pwmOutN | output | 1 | Complementary drive, low when disabled |

## Verification
The bench builds the block with `W` = 6, so duty, minimum and total are six-bit values and a period is at most a few dozen clocks. It then sweeps every duty value from zero to beyond saturation for several minimum/total pairs, including the tightest valid pair (1, 2). Each sweep point measures a full low phase and a full high phase at the pins against arithmetic expectations. With the small width, the saturation boundary, the invalid settings, the mid-period sample change and the complement behaviour in both `diffEn` states all fall within a few thousand clocks.

// File: rtl/sinePwmPkg.sv
package sinePwmPkg;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_OFF   = 2'd1,
    PH_ON    = 2'd2
  } pwmPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;  // capture duty and settings
    logic clr;    // restart interval counter
    logic inc;    // advance interval counter
  } pwmStrobe_t;

endpackage

// File: rtl/sinePwmDatapath.sv
module sinePwmDatapath
  import sinePwmPkg::*;
#(
  parameter int W = 12,
  localparam int LEN_W = W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  pwmStrobe_t       strobe,
  input  logic             sampleValid,
  input  logic [W-1:0]     sampleDuty,
  input  logic [W-1:0]     cfgMin,
  input  logic [W-1:0]     cfgTotal,
  output logic             cfgOk,
  output logic [LEN_W-1:0] onLen,
  output logic [LEN_W-1:0] offLen,
  output logic [LEN_W-1:0] cnt,
  output logic [W-1:0]     minLat,
  output logic [W-1:0]     dutyLat
);

  logic [W-1:0] pendDuty;
  logic [W-1:0] nextPend;
  logic [W-1:0] satDuty;
  logic [W-1:0] totLat;

  always_comb begin
    nextPend = sampleValid ? sampleDuty : pendDuty;
    satDuty  = (nextPend > cfgTotal) ? cfgTotal : nextPend;
    cfgOk    = (cfgMin != '0) && (cfgTotal > cfgMin);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendDuty <= '0;
    end else begin
      pendDuty <= nextPend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      minLat  <= '0;
      totLat  <= '0;
      dutyLat <= '0;
    end else if (strobe.latch) begin
      minLat  <= cfgMin;
      totLat  <= cfgTotal;
      dutyLat <= satDuty;
    end
  end

  always_comb begin
    onLen  = {1'b0, dutyLat} + {1'b0, minLat};
    offLen = {1'b0, totLat} + {1'b0, minLat} - {1'b0, dutyLat};
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clr) begin
      cnt <= '0;
    end else if (strobe.inc) begin
      cnt <= cnt + LEN_W'(1);
    end
  end

endmodule

// File: rtl/sinePwmControl.sv
module sinePwmControl
  import sinePwmPkg::*;
#(
  parameter int W = 12,
  localparam int LEN_W = W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgOk,
  input  logic             diffEn,
  input  logic [LEN_W-1:0] onLen,
  input  logic [LEN_W-1:0] offLen,
  input  logic [LEN_W-1:0] cnt,
  output pwmStrobe_t       strobe,
  output logic             pwmOut,
  output logic             pwmOutN
);

  pwmPhase_t phase;
  pwmPhase_t phaseNext;
  logic      offDone;
  logic      onDone;

  always_comb begin
    offDone   = (cnt == offLen - LEN_W'(1));
    onDone    = (cnt == onLen - LEN_W'(1));
    strobe    = '0;
    phaseNext = phase;
    unique case (phase)
      PH_START: begin
        strobe.latch = 1'b1;
        strobe.clr   = 1'b1;
        phaseNext    = cfgOk ? PH_OFF : PH_START;
      end
      PH_OFF: begin
        if (offDone) begin
          strobe.clr = 1'b1;
          phaseNext  = PH_ON;
        end else begin
          strobe.inc = 1'b1;
        end
      end
      PH_ON: begin
        if (onDone) begin
          strobe.latch = 1'b1;
          strobe.clr   = 1'b1;
          phaseNext    = cfgOk ? PH_OFF : PH_START;
        end else begin
          strobe.inc = 1'b1;
        end
      end
      default: begin
        strobe.clr = 1'b1;
        phaseNext  = PH_START;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_START;
    else     phase <= phaseNext;
  end

  assign pwmOut  = (phase == PH_ON);
  assign pwmOutN = diffEn && (phase == PH_OFF);

endmodule

// File: rtl/sinePwmTop.sv
module sinePwmTop
  import sinePwmPkg::*;
#(
  parameter int W = 12,
  localparam int LEN_W = W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleValid,
  input  logic [W-1:0] sampleDuty,
  input  logic [W-1:0] cfgMin,
  input  logic [W-1:0] cfgTotal,
  input  logic         diffEn,
  output logic         pwmOut,
  output logic         pwmOutN
);

  pwmStrobe_t       strobe;
  logic             cfgOk;
  logic [LEN_W-1:0] onLen;
  logic [LEN_W-1:0] offLen;
  logic [LEN_W-1:0] cnt;
  logic [W-1:0]     minLat;
  logic [W-1:0]     dutyLat;

  sinePwmDatapath #(.W(W)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .sampleValid(sampleValid), .sampleDuty(sampleDuty),
    .cfgMin(cfgMin), .cfgTotal(cfgTotal), .cfgOk(cfgOk),
    .onLen(onLen), .offLen(offLen), .cnt(cnt),
    .minLat(minLat), .dutyLat(dutyLat)
  );

  sinePwmControl #(.W(W)) uCtl (
    .clk(clk), .rst(rst), .cfgOk(cfgOk), .diffEn(diffEn),
    .onLen(onLen), .offLen(offLen), .cnt(cnt),
    .strobe(strobe), .pwmOut(pwmOut), .pwmOutN(pwmOutN)
  );

endmodule

// File: rtl/sinePwmChecker.sv
module sinePwmChecker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         diffEn,
  input logic         pwmOut,
  input logic         pwmOutN,
  input logic         latch,
  input logic [W-1:0] minLat,
  input logic [W-1:0] dutyLat
);

  logic [W+1:0] runHigh;

  always_ff @(posedge clk) begin
    if (rst)         runHigh <= '0;
    else if (pwmOut) runHigh <= runHigh + 1'b1;
    else             runHigh <= '0;
  end

  // R1
  a_r1_reset_low: assert property (@(posedge clk) rst |=> (!pwmOut && !pwmOutN));

  // R5
  a_r5_min_high: assert property (@(posedge clk) disable iff (rst)
    $fell(pwmOut) |-> (runHigh >= {2'b00, $past(minLat)}));

  // R6
  a_r6_hold_between_starts: assert property (@(posedge clk) disable iff (rst)
    !latch |=> ($stable(dutyLat) && $stable(minLat)));

  // R7
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(pwmOut && pwmOutN));

  // R8
  a_r8_comp_off: assert property (@(posedge clk) disable iff (rst)
    !diffEn |-> !pwmOutN);

endmodule

bind sinePwmTop sinePwmChecker #(.W(W)) uChk (
  .clk(clk), .rst(rst), .diffEn(diffEn), .pwmOut(pwmOut), .pwmOutN(pwmOutN),
  .latch(strobe.latch), .minLat(minLat), .dutyLat(dutyLat)
);

// File: tb/tb_sinePwmTop.sv
`timescale 1ns/1ps
module tb_sinePwmTop;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b1;
  logic [W-1:0] sampleDuty = '0;
  logic [W-1:0] cfgMin = 6'd3;
  logic [W-1:0] cfgTotal = 6'd10;
  logic diffEn = 1'b1;
  logic pwmOut, pwmOutN;

  int nTests = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  sinePwmTop #(.W(W)) dut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleDuty(sampleDuty),
    .cfgMin(cfgMin), .cfgTotal(cfgTotal), .diffEn(diffEn),
    .pwmOut(pwmOut), .pwmOutN(pwmOutN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns at the first sample of a new low phase
  task automatic waitFall();
    bit prev;
    prev = pwmOut;
    @(negedge clk);
    while (!(prev && !pwmOut)) begin
      prev = pwmOut;
      @(negedge clk);
    end
  endtask

  // measures one low then one high phase; checks complement pin throughout
  task automatic measure(output int lo, output int hi);
    int bad;
    bad = 0;
    lo = 0;
    hi = 0;
    while (!pwmOut) begin
      lo++;
      if (pwmOutN !== diffEn) bad++;
      @(negedge clk);
    end
    while (pwmOut) begin
      hi++;
      if (pwmOutN !== 1'b0) bad++;
      @(negedge clk);
    end
    if (diffEn) check(bad == 0, "R7 complement", bad, 0);
    else        check(bad == 0, "R8 complement held low", bad, 0);
  endtask

  task automatic sweepPoint(input int mn, input int tot, input int d);
    int lo, hi, sat;
    sampleDuty = W'(d);
    waitFall();
    waitFall();
    measure(lo, hi);
    sat = (d > tot) ? tot : d;
    if (d > tot) begin
      check(hi == tot + mn && lo == mn, "R4 saturation", hi * 100 + lo, (tot + mn) * 100 + mn);
    end else begin
      check(hi == sat + mn, "R2 high length", hi, sat + mn);
      check(lo == tot + mn - sat, "R3 low length", lo, tot + mn - sat);
    end
    check(hi + lo == tot + 2 * mn, "R3 period", hi + lo, tot + 2 * mn);
    check(hi >= mn, "R5 min width", hi, mn);
  endtask

  initial begin
    int lo, hi, highs;
    // R1 reset
    repeat (3) @(negedge clk);
    check(!pwmOut && !pwmOutN, "R1 reset low", {pwmOut, pwmOutN}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pwmOut, "R1 restart low phase", pwmOut, 0);

    // sweep (3,10) with complement
    for (int d = 0; d <= 12; d++) sweepPoint(3, 10, d);

    // tightest valid pair, complement off
    diffEn = 1'b0;
    cfgMin = 6'd1;
    cfgTotal = 6'd2;
    for (int d = 0; d <= 5; d++) sweepPoint(1, 2, d);

    diffEn = 1'b1;
    cfgMin = 6'd5;
    cfgTotal = 6'd20;
    for (int d = 0; d <= 63; d += 7) sweepPoint(5, 20, d);

    // R6: change during low phase applies next period only
    cfgMin = 6'd3;
    cfgTotal = 6'd10;
    sampleDuty = 6'd2;
    waitFall();
    waitFall();
    sampleDuty = 6'd8;
    cfgMin = 6'd4;
    measure(lo, hi);
    check(hi == 5 && lo == 11, "R6 current period kept", hi * 100 + lo, 511);
    measure(lo, hi);
    check(hi == 12 && lo == 6, "R6 next period updated", hi * 100 + lo, 1206);

    // R10: last valid sample wins, unqualified data ignored
    cfgMin = 6'd3;
    sampleValid = 1'b1;
    sampleDuty = 6'd4;
    @(negedge clk);
    sampleDuty = 6'd6;
    @(negedge clk);
    sampleValid = 1'b0;
    sampleDuty = 6'd1;
    waitFall();
    waitFall();
    measure(lo, hi);
    check(hi == 9 && lo == 7, "R10 last sample wins", hi * 100 + lo, 907);
    sampleValid = 1'b1;

    // R9: invalid settings park outputs low
    cfgMin = 6'd0;
    waitFall();
    highs = 0;
    repeat (60) begin
      @(negedge clk);
      if (pwmOut || pwmOutN) highs++;
    end
    check(highs == 0, "R9 zero minimum idles", highs, 0);
    cfgMin = 6'd4;
    cfgTotal = 6'd4;
    highs = 0;
    repeat (60) begin
      @(negedge clk);
      if (pwmOut || pwmOutN) highs++;
    end
    check(highs == 0, "R9 total not above minimum idles", highs, 0);
    cfgMin = 6'd3;
    cfgTotal = 6'd10;
    sampleDuty = 6'd5;
    waitFall();
    measure(lo, hi);
    check(hi == 8 && lo == 8, "R9 recovery", hi * 100 + lo, 808);

    // R1 mid-run reset
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!pwmOut && !pwmOutN, "R1 reset mid-run", {pwmOut, pwmOutN}, 0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule